// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the single decision point for operand bypassing and pipeline steering in a five-stage in-order integer pipeline. Branches in this pipeline are compared in the decode stage. Each cycle it looks at the register fields held in the decode, execute, memory and writeback pipeline registers. From them it produces two bypass selects for the execute-stage operand muxes. It also produces the enables for the program counter and the fetch/decode register, a bubble select that zeroes the control word entering execute, and a flush for the fetch/decode register.

Bypassing chooses the newest producer. A result still in the memory stage is preferred over one in writeback, and register 0 is never bypassed. A load followed at once by a consumer of its destination cannot be served by bypassing. For that case the block freezes fetch and decode for one cycle and sends a bubble down. On the next cycle the loaded value is reached through the writeback bypass. Branches are predicted not taken. When decode resolves a branch as taken, the one instruction fetched behind it is flushed. A small controller with two states enforces the one-cycle length of a stall. S_FLOW is the normal state. The transition T_HAZARD moves S_FLOW to S_REPLAY when a load-use hazard is seen, and the transition T_RESUME always moves S_REPLAY back to S_FLOW after one cycle. Reset enters S_FLOW.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand is bypassed from a stage only when that stage's write enable is 1 and its destination register is non-zero. Otherwise the select is 00 and the register file value is used.
- R2: When the memory stage and the writeback stage both qualify for the same execute source register, the select is 10, so the memory stage wins.
- R3: The select encoding is 00 for the register file, 10 for the memory-stage result and 01 for the writeback-stage result. fwd_a follows ex_rs and fwd_b follows ex_rt, each on its own, and the value 11 never appears.
- R4: In S_FLOW, a load-use hazard exists when ex_mem_read is 1 and ex_rt equals id_rs or id_rt. In that same cycle pc_we is 0, ifid_we is 0 and ex_bubble is 1.
- R5: A stall lasts exactly one cycle. In the cycle after a stall (S_REPLAY) no stall is raised, even with unchanged inputs. The cycle after that is back in S_FLOW and detects hazards again.
- R6: With ex_mem_read at 0, or with no register match, pc_we and ifid_we are 1 and ex_bubble is 0.
- R7: id_branch_taken at 1 without a stall gives ifid_flush of 1 in the same cycle. ifid_flush is 0 otherwise.
- R8: A stall takes precedence over a branch flush. When both apply in one cycle, ifid_flush is 0 and the stall outputs are as in R4.
- R9: Reset places the controller in S_FLOW, so the first load-use hazard after reset is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the stall controller |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| ex_rs | input | AW | First source register of the execute instruction |
| ex_rt | input | AW | Second source / load destination of the execute instruction |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register in the memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination register in the writeback stage |
| wb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| id_branch_taken | input | 1 | Decode resolved a branch as taken |
| fwd_a | output | 2 | Bypass select for operand A |
| fwd_b | output | 2 | Bypass select for operand B |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_bubble | output | 1 | Zero the control word entering execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |

## Verification
Every output is combinational in the current inputs and the controller state, so each result is due in the same cycle its stimulus is applied. The bench drives fields just after a falling edge and samples a few nanoseconds later, before the next rising edge. Only the stall controller carries history: a stall raised in one cycle moves it to S_REPLAY at the next rising edge. The R5 checks therefore hold the inputs across two edges and sample in each of the following cycles. The chained run keeps its own one-bit replay model, which is updated at each edge from the stall it predicted.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_REG = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        S_FLOW   = 1'b0,
        S_REPLAY = 1'b1
    } hz_state_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    sel
);
    import hz_pkg::*;

    logic mem_hit;
    logic wb_hit;
    fwd_sel_e pick;

    always_comb begin
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)     pick = FWD_MEM;
        else if (wb_hit) pick = FWD_WB;
        else             pick = FWD_REG;
    end

    assign sel = pick;
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rt,
    input  logic          ex_mem_read,
    output logic          hazard
);
    logic rs_match;
    logic rt_match;

    always_comb begin
        rs_match = (ex_rt == id_rs);
        rt_match = (ex_rt == id_rt);
        hazard   = ex_mem_read && (rs_match || rt_match);
    end
endmodule

// File: rtl/hz_ctrl_fsm.sv
module hz_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    input  logic branch_taken,
    output logic pc_we,
    output logic ifid_we,
    output logic ex_bubble,
    output logic ifid_flush
);
    import hz_pkg::*;

    hz_state_e state_q;
    hz_state_e state_d;
    logic      stall;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FLOW;
        else        state_q <= state_d;
    end

    // Transitions: T_HAZARD (S_FLOW -> S_REPLAY), T_RESUME (S_REPLAY -> S_FLOW).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FLOW:   if (hazard) state_d = S_REPLAY;
            S_REPLAY: state_d = S_FLOW;
        endcase
    end

    // Outputs.
    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            S_FLOW:   stall = hazard;
            S_REPLAY: stall = 1'b0;
        endcase
        pc_we      = !stall;
        ifid_we    = !stall;
        ex_bubble  = stall;
        ifid_flush = branch_taken && !stall;
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic          ex_mem_read,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_reg_write,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_reg_write,
    input  logic          id_branch_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          ex_bubble,
    output logic          ifid_flush
);
    localparam int NOPS = 2;

    logic [AW-1:0] op_src [NOPS];
    logic [1:0]    op_sel [NOPS];
    logic          lu_hazard;

    assign op_src[0] = ex_rs;
    assign op_src[1] = ex_rt;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_fwd_pick #(.AW(AW)) u_pick (
            .src    (op_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_reg_write),
            .wb_rd  (wb_rd),
            .wb_we  (wb_reg_write),
            .sel    (op_sel[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hz_load_use #(.AW(AW)) u_lu (
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .ex_rt       (ex_rt),
        .ex_mem_read (ex_mem_read),
        .hazard      (lu_hazard)
    );

    hz_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hazard       (lu_hazard),
        .branch_taken (id_branch_taken),
        .pc_we        (pc_we),
        .ifid_we      (ifid_we),
        .ex_bubble    (ex_bubble),
        .ifid_flush   (ifid_flush)
    );
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs,
    input logic          ex_mem_read,
    input logic [AW-1:0] mem_rd,
    input logic          mem_reg_write,
    input logic [AW-1:0] wb_rd,
    input logic          wb_reg_write,
    input logic          id_branch_taken,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_we,
    input logic          ifid_we,
    input logic          ex_bubble,
    input logic          ifid_flush
);
    p_zero_never_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_reg_write || mem_rd == '0) && (!wb_reg_write || wb_rd == '0))
        |-> (fwd_a == 2'b00 && fwd_b == 2'b00));

    p_mem_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_reg_write && mem_rd != '0 && mem_rd == ex_rs) |-> (fwd_a == 2'b10));

    p_legal_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    p_stall_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (!pc_we && !ifid_we));

    p_stall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> !ex_bubble);

    p_no_load_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> (pc_we && ifid_we && !ex_bubble));

    p_flush_on_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch_taken && !ex_bubble) |-> ifid_flush);

    p_flush_yields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> !ifid_flush);
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ex_rs           (ex_rs),
    .ex_mem_read     (ex_mem_read),
    .mem_rd          (mem_rd),
    .mem_reg_write   (mem_reg_write),
    .wb_rd           (wb_rd),
    .wb_reg_write    (wb_reg_write),
    .id_branch_taken (id_branch_taken),
    .fwd_a           (fwd_a),
    .fwd_b           (fwd_b),
    .pc_we           (pc_we),
    .ifid_we         (ifid_we),
    .ex_bubble       (ex_bubble),
    .ifid_flush      (ifid_flush)
);

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic          ex_mem_read = 1'b0, mem_reg_write = 1'b0, wb_reg_write = 1'b0;
    logic          id_branch_taken = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          pc_we, ifid_we, ex_bubble, ifid_flush;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pipe_hazard_unit #(.AW(AW)) u_pipe_hazard_unit (
        .clk, .rst_n, .id_rs, .id_rt, .ex_rs, .ex_rt, .ex_mem_read,
        .mem_rd, .mem_reg_write, .wb_rd, .wb_reg_write, .id_branch_taken,
        .fwd_a, .fwd_b, .pc_we, .ifid_we, .ex_bubble, .ifid_flush
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive all fields just after a falling edge, then settle.
    task automatic apply(input int irs, input int irt, input int ers, input int ert,
                         input bit mr, input int mrd, input bit mwe,
                         input int wrd, input bit wwe, input bit br);
        @(negedge clk);
        id_rs = AW'(irs); id_rt = AW'(irt); ex_rs = AW'(ers); ex_rt = AW'(ert);
        ex_mem_read = mr; mem_rd = AW'(mrd); mem_reg_write = mwe;
        wb_rd = AW'(wrd); wb_reg_write = wwe; id_branch_taken = br;
        #2;
    endtask

    function automatic int exp_sel(int src, int mrd, bit mwe, int wrd, bit wwe);
        if (mwe && mrd != 0 && mrd == src) return 2;
        if (wwe && wrd != 0 && wrd == src) return 1;
        return 0;
    endfunction

    task automatic chk_stall(input string req, input bit st);
        chk(req, "pc_we", pc_we, !st);
        chk(req, "ifid_we", ifid_we, !st);
        chk(req, "ex_bubble", ex_bubble, st);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk("R9", "fwd_a idle", fwd_a, 0);
        chk("R9", "fwd_b idle", fwd_b, 0);
        chk_stall("R9", 0);
        chk("R9", "flush idle", ifid_flush, 0);
        apply(4, 7, 0, 4, 1, 0, 0, 0, 0, 0);
        chk_stall("R9", 1);
    endtask

    task automatic t_forward();
        apply(0, 0, 3, 6, 0, 3, 1, 6, 1, 0);
        chk("R3", "fwd_a mem", fwd_a, 2);
        chk("R3", "fwd_b wb", fwd_b, 1);
        apply(0, 0, 3, 6, 0, 3, 0, 6, 0, 0);
        chk("R1", "fwd_a no we", fwd_a, 0);
        chk("R1", "fwd_b no we", fwd_b, 0);
        apply(0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
        chk("R1", "fwd_a r0", fwd_a, 0);
        chk("R1", "fwd_b r0", fwd_b, 0);
        apply(0, 0, 9, 9, 0, 2, 1, 9, 1, 0);
        chk("R3", "fwd_a wb only", fwd_a, 1);
        chk("R3", "fwd_b wb only", fwd_b, 1);
    endtask

    task automatic t_priority();
        apply(0, 0, 5, 5, 0, 5, 1, 5, 1, 0);
        chk("R2", "fwd_a both", fwd_a, 2);
        chk("R2", "fwd_b both", fwd_b, 2);
        apply(0, 0, 5, 8, 0, 0, 1, 5, 1, 0);
        chk("R2", "fwd_a mem r0 falls to wb", fwd_a, 1);
    endtask

    task automatic t_loaduse();
        apply(1, 2, 0, 9, 0, 0, 0, 0, 0, 0);
        chk_stall("R6", 0);
        apply(1, 2, 0, 9, 1, 0, 0, 0, 0, 0);
        chk_stall("R6", 0);
        apply(1, 2, 0, 9, 0, 0, 0, 0, 0, 0);
        apply(9, 2, 0, 9, 1, 0, 0, 0, 0, 0);
        chk_stall("R4", 1);
        apply(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 9, 0, 9, 1, 0, 0, 0, 0, 0);
        chk_stall("R4", 1);
        apply(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_one_cycle();
        apply(12, 3, 0, 12, 1, 0, 0, 0, 0, 0);
        chk_stall("R5", 1);
        apply(12, 3, 0, 12, 1, 0, 0, 0, 0, 0);
        chk_stall("R5", 0);
        apply(12, 3, 0, 12, 1, 0, 0, 0, 0, 0);
        chk_stall("R5", 1);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_branch();
        apply(1, 2, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R7", "flush taken", ifid_flush, 1);
        chk_stall("R7", 0);
        apply(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7", "flush not taken", ifid_flush, 0);
        apply(1, 2, 0, 2, 1, 0, 0, 0, 0, 1);
        chk("R8", "flush under stall", ifid_flush, 0);
        chk_stall("R8", 1);
        apply(1, 2, 0, 2, 1, 0, 0, 0, 0, 1);
        chk("R8", "flush after stall", ifid_flush, 1);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Dependent chains over a small register range, against a reference model.
    task automatic t_chain();
        int unsigned seed = 32'h1234_5678;
        bit replay = 0;
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) begin
            int f[10];
            bit hz;
            for (int k = 0; k < 10; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                f[k] = int'((seed >> 16) & 32'h3);
            end
            apply(f[0], f[1], f[2], f[3], f[4][0], f[5], f[6][0], f[7], f[8][0], f[9][0]);
            hz = !replay && f[4][0] && (f[3] == f[0] || f[3] == f[1]);
            chk("R3", "chain fwd_a", fwd_a, exp_sel(f[2], f[5], f[6][0], f[7], f[8][0]));
            chk("R3", "chain fwd_b", fwd_b, exp_sel(f[3], f[5], f[6][0], f[7], f[8][0]));
            chk_stall("R5", hz);
            chk("R8", "chain flush", ifid_flush, f[9][0] && !hz);
            replay = hz;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_forward();
        t_priority();
        t_loaduse();
        t_one_cycle();
        t_branch();
        t_chain();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule